// File: doc/BRIEF.md
# Stack-Window Register Operand Selector

This block resolves the three register operands of a register-to-register instruction against a register space with four views. The first is a 128-word circular stack. The second is a 16-entry local window that aliases the stack at a moving base L. The third is 16 auxiliary registers, and the fourth is 12 constant registers. Each 4-bit operand field either names a slot in the local, auxiliary or constant bank directly, or names a word relative to the stack pointer S. Some of the stack-relative codes also move S as a side effect. All arithmetic on S and L wraps modulo the stack size, and nothing checks for overflow or underflow.

Decoding is combinational. From the 16-bit operand word and the current S and L, the block drives a bank selector and a physical index for each of Ra, Rb and Rc, the read data of Ra and Rb, and the S value that should follow the instruction. The block holds the register storage itself. A small ALU combines Ra and Rb, and on an issued instruction the result is written into Rc at the next clock edge, so the decode can be checked end to end. Constants are loaded through their own port. An instruction that names a constant as its destination does not change that constant and raises a flag instead.

Top module: `stkwin_opsel`

## Requirements
- R1: After reset, every stack, auxiliary and constant register reads as zero.
- R2: The operand word is laid out as c=[15:12], a=[11:8], a-option=[7], c-option=[6], b-option=[5], aux=[4], b=[3:0]. With its option bit clear and aux clear, a field n selects bank 0 (stack) at index (n+L) mod 128.
- R3: With its option bit clear and aux set, a field n selects bank 1 (auxiliary) at index n.
- R4: With its option bit set, field values 0 to 11 select bank 2 (constant) at index n, whatever the value of aux.
- R5: For Ra or Rb with the option bit set, code 12 selects stack index S and code 13 selects stack index (S-1) mod 128. Neither code changes S.
- R6: For Ra or Rb with the option bit set, code 14 selects stack index S and code 15 selects stack index S-1. Each of these lowers the adjustment by one, and both sources together lower it by two.
- R7: For Rc with the option bit set, codes 12 and 13 select S and S-1. Codes 14 and 15 both select (S+1) mod 128 and raise the adjustment by one. All indices are taken from the S value at the start of the instruction.
- R8: s_next equals (S + adjustment) mod 128, where the adjustment starts at zero for each instruction.
- R9: When issue is high, the result of Ra op Rb is written into Rc at the clock edge and can be read by any later instruction. The op is selected by fn: 0 add, 1 subtract (a-b), 2 and, 3 xor.
- R10: When issue is high and Rc selects a constant, rc_const is high and the constant keeps its value.
- R11: A constant load with index below 12 writes that constant at the clock edge. A load with index 12 to 15 changes no register.
- R12: ra_val and rb_val show the present content of the selected registers, in the same cycle as the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Execute the decoded instruction this cycle |
| op_word | input | 16 | Operand specifier word |
| fn | input | 2 | ALU function select |
| s_cur | input | 7 | Current stack pointer |
| l_cur | input | 7 | Current local base |
| cld_en | input | 1 | Constant load strobe |
| cld_idx | input | 4 | Constant load index |
| cld_data | input | 32 | Constant load data |
| ra_bank | output | 2 | Ra bank: 0 stack, 1 aux, 2 constant |
| ra_idx | output | 7 | Ra physical index |
| rb_bank | output | 2 | Rb bank |
| rb_idx | output | 7 | Rb physical index |
| rc_bank | output | 2 | Rc bank |
| rc_idx | output | 7 | Rc physical index |
| s_next | output | 7 | Stack pointer after the instruction |
| ra_val | output | 32 | Ra read data |
| rb_val | output | 32 | Rb read data |
| alu_res | output | 32 | ALU result |
| rc_const | output | 1 | Issued instruction names a constant as destination |

## Verification
An incorrect index decode or wrap shows at once on the idx and bank outputs, in the same cycle as the instruction. A write that lands in the wrong slot is invisible until a later instruction reads the intended slot or the wrongly hit slot, so the bench writes a slot and reads it back within one or two instructions. The adjustment error that matters most is on s_next, which shows in the same cycle, and the bench drives S across the 0/127 boundary to expose errors in the modular arithmetic. A constant corrupted by a wrongly suppressed or wrongly accepted write shows only when that constant is next read, so each protected constant is read right after the attempt.

// File: rtl/stkwin_opsel.sv
`timescale 1ns/1ps
module stkwin_opsel #(
  parameter int DW     = 32,
  parameter int SDEPTH = 128,
  parameter int NAUX   = 16,
  parameter int NCONST = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [15:0]       op_word,
  input  logic [1:0]        fn,
  input  logic [$clog2(SDEPTH)-1:0] s_cur,
  input  logic [$clog2(SDEPTH)-1:0] l_cur,
  input  logic              cld_en,
  input  logic [3:0]        cld_idx,
  input  logic [DW-1:0]     cld_data,
  output logic [1:0]        ra_bank,
  output logic [$clog2(SDEPTH)-1:0] ra_idx,
  output logic [1:0]        rb_bank,
  output logic [$clog2(SDEPTH)-1:0] rb_idx,
  output logic [1:0]        rc_bank,
  output logic [$clog2(SDEPTH)-1:0] rc_idx,
  output logic [$clog2(SDEPTH)-1:0] s_next,
  output logic [DW-1:0]     ra_val,
  output logic [DW-1:0]     rb_val,
  output logic [DW-1:0]     alu_res,
  output logic              rc_const
);
  localparam int SW  = $clog2(SDEPTH);
  localparam int AW  = $clog2(NAUX);
  localparam int KW  = $clog2(NCONST);
  localparam logic [1:0] BK_STK = 2'd0;
  localparam logic [1:0] BK_AUX = 2'd1;
  localparam logic [1:0] BK_CON = 2'd2;

  typedef struct packed {
    logic [1:0]    bank;
    logic [SW-1:0] idx;
    logic          adj;
  } sel_t;

  logic [DW-1:0] stk_q [SDEPTH];
  logic [DW-1:0] aux_q [NAUX];
  logic [DW-1:0] con_q [NCONST];

  wire [3:0] f_c   = op_word[15:12];
  wire [3:0] f_a   = op_word[11:8];
  wire       opt_a = op_word[7];
  wire       opt_c = op_word[6];
  wire       opt_b = op_word[5];
  wire       use_x = op_word[4];
  wire [3:0] f_b   = op_word[3:0];

  function automatic sel_t pick(input logic [3:0] f, input logic opt, input logic ax,
                                input logic dst, input logic [SW-1:0] s,
                                input logic [SW-1:0] l);
    sel_t r;
    r.adj = 1'b0;
    if (!opt) begin
      r.bank = ax ? BK_AUX : BK_STK;
      r.idx  = ax ? SW'(f) : l + SW'(f);
    end else if (int'(f) < NCONST) begin
      r.bank = BK_CON;
      r.idx  = SW'(f);
    end else begin
      r.bank = BK_STK;
      if (dst) begin
        r.adj = f[1];
        r.idx = f[1] ? s + 1'b1 : (f[0] ? s - 1'b1 : s);
      end else begin
        r.adj = f[1];
        r.idx = f[0] ? s - 1'b1 : s;
      end
    end
    return r;
  endfunction

  sel_t sa, sb, sc;
  assign sa = pick(f_a, opt_a, use_x, 1'b0, s_cur, l_cur);
  assign sb = pick(f_b, opt_b, use_x, 1'b0, s_cur, l_cur);
  assign sc = pick(f_c, opt_c, use_x, 1'b1, s_cur, l_cur);

  assign ra_bank = sa.bank;
  assign ra_idx  = sa.idx;
  assign rb_bank = sb.bank;
  assign rb_idx  = sb.idx;
  assign rc_bank = sc.bank;
  assign rc_idx  = sc.idx;

  assign s_next = s_cur + SW'(sc.adj) - SW'(sa.adj) - SW'(sb.adj);

  assign ra_val = (sa.bank == BK_STK) ? stk_q[sa.idx] :
                  (sa.bank == BK_AUX) ? aux_q[sa.idx[AW-1:0]] : con_q[sa.idx[KW-1:0]];
  assign rb_val = (sb.bank == BK_STK) ? stk_q[sb.idx] :
                  (sb.bank == BK_AUX) ? aux_q[sb.idx[AW-1:0]] : con_q[sb.idx[KW-1:0]];

  always_comb begin
    case (fn)
      2'd0:    alu_res = ra_val + rb_val;
      2'd1:    alu_res = ra_val - rb_val;
      2'd2:    alu_res = ra_val & rb_val;
      default: alu_res = ra_val ^ rb_val;
    endcase
  end

  assign rc_const = issue && (sc.bank == BK_CON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SDEPTH; i++) stk_q[i] <= '0;
      for (int i = 0; i < NAUX; i++)   aux_q[i] <= '0;
      for (int i = 0; i < NCONST; i++) con_q[i] <= '0;
    end else begin
      if (issue && sc.bank == BK_STK) stk_q[sc.idx] <= alu_res;
      if (issue && sc.bank == BK_AUX) aux_q[sc.idx[AW-1:0]] <= alu_res;
      if (cld_en && int'(cld_idx) < NCONST) con_q[cld_idx[KW-1:0]] <= cld_data;
    end
  end
endmodule

module stkwin_opsel_chk #(
  parameter int SW = 7,
  parameter int DW = 32,
  parameter int NCONST = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue,
  input logic          cld_en,
  input logic [1:0]    ra_bank,
  input logic [SW-1:0] ra_idx,
  input logic [1:0]    rc_bank,
  input logic [SW-1:0] rc_idx,
  input logic [SW-1:0] s_cur,
  input logic [SW-1:0] s_next,
  input logic [DW-1:0] ra_val,
  input logic [DW-1:0] alu_res
);
  logic [SW-1:0] step;
  assign step = s_next - s_cur;

  AST_SNEXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step == SW'(0)) || (step == SW'(1)) || (step == {SW{1'b1}}) || (step == {{(SW-1){1'b1}}, 1'b0})); // R8
  AST_CONST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_bank == 2'd2) |-> (int'(ra_idx) < NCONST)); // R4
  AST_NO_BANK3: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_bank != 2'd3) && (rc_bank != 2'd3)); // R3
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && rc_bank == 2'd0) |=>
      (!(ra_bank == 2'd0 && ra_idx == $past(rc_idx)) || ra_val == $past(alu_res))); // R9
  AST_CONST_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && rc_bank == 2'd2 && ra_bank == 2'd2 && ra_idx == rc_idx && !cld_en) |=>
      (!(ra_bank == 2'd2 && ra_idx == $past(ra_idx)) || ra_val == $past(ra_val))); // R10
endmodule

bind stkwin_opsel stkwin_opsel_chk #(.SW(SW), .DW(DW), .NCONST(NCONST)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .cld_en(cld_en),
  .ra_bank(ra_bank), .ra_idx(ra_idx), .rc_bank(rc_bank), .rc_idx(rc_idx),
  .s_cur(s_cur), .s_next(s_next), .ra_val(ra_val), .alu_res(alu_res));

// File: tb/stkwin_opsel_bench.sv
`timescale 1ns/1ps
module stkwin_opsel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0;
  logic [15:0] op_word = '0;
  logic [1:0] fn = '0;
  logic [6:0] s_cur = '0, l_cur = '0;
  logic cld_en = 1'b0;
  logic [3:0] cld_idx = '0;
  logic [31:0] cld_data = '0;
  logic [1:0] ra_bank, rb_bank, rc_bank;
  logic [6:0] ra_idx, rb_idx, rc_idx, s_next;
  logic [31:0] ra_val, rb_val, alu_res;
  logic rc_const;

  always #2.5 clk = ~clk;

  stkwin_opsel u_stkwin_opsel (.*);

  typedef struct {
    string tag;
    int ab, ai, bb, bi, cb, ci, sn;
    logic [31:0] av, bv, res;
    bit cc;
  } item_t;
  item_t q[$];

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] m_stk [128];
  logic [31:0] m_aux [16];
  logic [31:0] m_con [12];

  function automatic logic [15:0] mk(int c, int a, bit ao, bit co, bit bo, bit ax, int b);
    return {4'(c), 4'(a), ao, co, bo, ax, 4'(b)};
  endfunction

  function automatic void bdec(input int f, input bit opt, input bit ax, input bit dst,
                               input int s, input int l, output int bank, output int idx,
                               output int adj);
    adj = 0;
    if (!opt) begin
      if (ax) begin bank = 1; idx = f; end
      else begin bank = 0; idx = (f + l) % 128; end
    end else if (f < 12) begin
      bank = 2; idx = f;
    end else begin
      bank = 0;
      if (dst) begin
        if (f == 12) idx = s;
        else if (f == 13) idx = (s + 127) % 128;
        else begin idx = (s + 1) % 128; adj = 1; end
      end else begin
        idx = (f % 2 == 1) ? (s + 127) % 128 : s;
        adj = (f >= 14) ? -1 : 0;
      end
    end
  endfunction

  function automatic logic [31:0] mval(int bank, int idx);
    if (bank == 0) return m_stk[idx];
    if (bank == 1) return m_aux[idx];
    return m_con[idx];
  endfunction

  task automatic run(string tag, logic [15:0] w, int f, int s, int l);
    item_t it;
    int adja, adjb, adjc;
    @(posedge clk); #1;
    issue = 1'b1; cld_en = 1'b0; op_word = w; fn = 2'(f);
    s_cur = 7'(s); l_cur = 7'(l);
    it.tag = tag;
    bdec(int'(w[11:8]), w[7], w[4], 1'b0, s, l, it.ab, it.ai, adja);
    bdec(int'(w[3:0]),  w[5], w[4], 1'b0, s, l, it.bb, it.bi, adjb);
    bdec(int'(w[15:12]), w[6], w[4], 1'b1, s, l, it.cb, it.ci, adjc);
    it.sn = (s + 128 + adja + adjb + adjc) % 128;
    it.av = mval(it.ab, it.ai);
    it.bv = mval(it.bb, it.bi);
    case (f)
      0: it.res = it.av + it.bv;
      1: it.res = it.av - it.bv;
      2: it.res = it.av & it.bv;
      default: it.res = it.av ^ it.bv;
    endcase
    it.cc = (it.cb == 2);
    q.push_back(it);
    if (it.cb == 0) m_stk[it.ci] = it.res;
    else if (it.cb == 1) m_aux[it.ci] = it.res;
  endtask

  task automatic cload(int idx, logic [31:0] d);
    @(posedge clk); #1;
    issue = 1'b0; cld_en = 1'b1; cld_idx = 4'(idx); cld_data = d;
    if (idx < 12) m_con[idx] = d;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    issue = 1'b0; cld_en = 1'b0;
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && issue && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, "ra_bank", 32'(ra_bank), 32'(it.ab));
      chk(it.tag, "ra_idx",  32'(ra_idx),  32'(it.ai));
      chk(it.tag, "rb_bank", 32'(rb_bank), 32'(it.bb));
      chk(it.tag, "rb_idx",  32'(rb_idx),  32'(it.bi));
      chk(it.tag, "rc_bank", 32'(rc_bank), 32'(it.cb));
      chk(it.tag, "rc_idx",  32'(rc_idx),  32'(it.ci));
      chk(it.tag, "s_next",  32'(s_next),  32'(it.sn));
      chk(it.tag, "ra_val",  ra_val, it.av);
      chk(it.tag, "rb_val",  rb_val, it.bv);
      chk(it.tag, "alu_res", alu_res, it.res);
      chk(it.tag, "rc_const", 32'(rc_const), 32'(it.cc));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) m_stk[i] = '0;
    for (int i = 0; i < 16; i++)  m_aux[i] = '0;
    for (int i = 0; i < 12; i++)  m_con[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset contents read zero (constant 3, local 5, aux 9)
    run("R1", mk(0, 3, 1, 0, 0, 0, 5), 0, 10, 0);
    run("R1", mk(0, 9, 0, 0, 1, 1, 7), 0, 10, 0);
    // R11: constant loads, index 12 ignored
    cload(0, 32'd100);
    cload(1, 32'd7);
    cload(5, 32'hF0F0);
    cload(12, 32'hDEAD_BEEF);
    // R11 R4: const 4 and 8 still zero, const 0/1 loaded; aux set does not matter
    run("R11", mk(0, 4, 1, 0, 1, 1, 8), 0, 50, 120);
    run("R4", mk(0, 0, 1, 0, 1, 1, 1), 0, 50, 120);
    // R2 R9: write local 10 with L=120 -> index 2
    run("R2", mk(10, 0, 1, 0, 1, 0, 1), 0, 50, 120);
    run("R12", mk(0, 10, 0, 0, 1, 0, 1), 0, 50, 120);
    // R3 R9: aux 3 = const0 - const1
    run("R3", mk(3, 0, 1, 0, 1, 1, 1), 1, 50, 0);
    run("R3", mk(4, 3, 0, 0, 1, 1, 5), 2, 50, 0);
    run("R9", mk(6, 3, 0, 0, 0, 1, 4), 3, 50, 0);
    // R7 R8: push via code 14 at S=0 -> index 1, S becomes 1
    run("R7", mk(14, 0, 1, 1, 1, 0, 5), 0, 0, 0);
    // R7: code 15 also pushes; code 12/13 keep S
    run("R7", mk(15, 1, 1, 1, 1, 0, 5), 0, 1, 0);
    run("R7", mk(12, 12, 1, 1, 1, 0, 13), 0, 2, 0);
    run("R7", mk(13, 0, 1, 1, 1, 0, 0), 0, 0, 0);
    // R5: 12/13 at S=0 wrap to 127, no adjustment
    run("R5", mk(0, 13, 1, 0, 1, 0, 12), 0, 0, 0);
    // R6 R8: 15 and 14 at S=1 -> S wraps 1 -> 127
    run("R6", mk(0, 15, 1, 0, 1, 0, 14), 1, 1, 0);
    run("R8", mk(15, 14, 1, 1, 1, 0, 12), 0, 0, 0);
    // R10: constant destination suppressed, then reread
    run("R10", mk(5, 0, 1, 1, 1, 0, 1), 0, 20, 0);
    run("R10", mk(0, 5, 1, 0, 1, 0, 5), 2, 20, 0);
    idle();
    idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule